// File: doc/BRIEF.md
# Shared-Memory Mailbox with Ownership Handoff

This block is a small register window shared by two agents: a requester and a responder. It holds eight 32-bit words, which together make a 256-bit message area. The requester fills the words it needs. Its write to the last word (index 7) passes ownership of the window to the responder, and the responder receives a one-cycle notify pulse. The responder reads the message, writes its response header into word 7, and that write gives ownership back to the requester.

Word 7 carries a header:

| Bits | Field |
|------|-------|
| 2:0 | message type |
| 5:3 | version |
| 6 | reserved |
| 7 | direction (0 = request, 1 = response) |
| 15:8 | status |
| 23:16 | reserved |
| 24 | reset-requester flag |
| 30:25 | reserved |
| 31 | owner |

Bits 30:0 are stored exactly as written. Bit 31 is never stored. It always reads the current owner: 1 means the responder owns the window, 0 means the requester owns it. While the requester is held in reset, the requester port reads word 7 as all-ones. This lets a polling requester recognise the reset condition. The block does not interpret the payload.

Top module: `mbox_window`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), all eight words read 0, the requester owns the window (`rsp_owns` = 0, word 7 bit 31 = 0) and `rsp_notify` is 0.
- R2: While the requester owns the window, a requester write to words 0 to 6 stores the data, which then reads back on both ports. Ownership stays unchanged.
- R3: While the requester owns the window, a requester write to word 7 stores bits 30:0 and sets `rsp_owns` from the next cycle on. Word 7 then reads with bit 31 = 1, whatever the written bit 31 was.
- R4: `rsp_notify` is high for exactly one cycle, and that cycle is the first cycle in which `rsp_owns` is 1 after a handoff.
- R5: Requester writes to any word have no effect while the responder owns the window.
- R6: Responder writes to any word have no effect while the requester owns the window.
- R7: While the responder owns the window, a responder write to word 7 stores bits 30:0 and clears `rsp_owns` from the next cycle on. Word 7 then reads with bit 31 = 0, even if the written bit 31 was 1. Responder writes to words 0 to 6 are stored without a change of owner.
- R8: While `req_hold` is 1, the requester port reads word 7 as 32'hFFFFFFFF. Other words on the requester port, and every word on the responder port, read normally. Stored contents are kept.
- R9: A message that consists only of a word-7 write hands ownership over and leaves words 0 to 6 at their previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_hold | input | 1 | Requester is held in reset; forces the requester's word-7 readback to all-ones |
| req_wr_en | input | 1 | Requester write strobe |
| req_addr | input | 3 | Requester word index for reads and writes |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data (combinational from `req_addr`) |
| rsp_wr_en | input | 1 | Responder write strobe |
| rsp_addr | input | 3 | Responder word index for reads and writes |
| rsp_wdata | input | 32 | Responder write data |
| rsp_rdata | output | 32 | Responder read data (combinational from `rsp_addr`) |
| rsp_owns | output | 1 | 1 while the responder owns the window |
| rsp_notify | output | 1 | One-cycle pulse on each handoff to the responder |

## Verification
The properties assume that write strobes and addresses are known values at every clock edge after reset. They also assume that `rst` is held for at least two edges, so the ownership register is defined before any property is evaluated. The bench drives every input on the falling edge, holds reset for several cycles, and raises a strobe for exactly one cycle per write. Each write is observed at the following falling edge. Writes issued by the side that does not own the window are deliberate: they exercise the gating, and the properties on ownership changes must still hold in that case.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    // Ownership tracker state: owner flag plus registered handoff pulse
    typedef struct packed {
        logic owned;
        logic notify;
    } own_state_t;
endpackage

// File: rtl/mbox_store.sv
module mbox_store #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [WORD_W-1:0]       wr_data,
    output logic [WORDS*WORD_W-1:0] words_flat
);
    logic [WORD_W-1:0] mem_d [WORDS];
    logic [WORD_W-1:0] mem_q [WORDS];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_flat
        assign words_flat[g*WORD_W +: WORD_W] = mem_q[g];
    end
endmodule

// File: rtl/mbox_owner.sv
module mbox_owner (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic give,
    output logic owned,
    output logic notify
);
    import mbox_pkg::*;

    own_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.notify = 1'b0;
        if (take && !st_q.owned) begin
            st_d.owned  = 1'b1;
            st_d.notify = 1'b1;
        end else if (give && st_q.owned) begin
            st_d.owned  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign owned  = st_q.owned;
    assign notify = st_q.notify;
endmodule

// File: rtl/mbox_readmux.sv
module mbox_readmux #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(WORDS),
    localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1)
) (
    input  logic [WORDS*WORD_W-1:0] words_flat,
    input  logic [AW-1:0]           addr,
    input  logic                    owned,
    input  logic                    force_ones,
    output logic [WORD_W-1:0]       rdata
);
    always_comb begin
        rdata = words_flat[int'(addr)*WORD_W +: WORD_W];
        if (addr == LAST_A) begin
            rdata[WORD_W-1] = owned;
            if (force_ones) begin
                rdata = '1;
            end
        end
    end
endmodule

// File: rtl/mbox_window.sv
module mbox_window #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(WORDS),
    localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_hold,
    input  logic              req_wr_en,
    input  logic [AW-1:0]     req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] req_rdata,
    input  logic              rsp_wr_en,
    input  logic [AW-1:0]     rsp_addr,
    input  logic [WORD_W-1:0] rsp_wdata,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_owns,
    output logic              rsp_notify
);
    logic                    req_acc, rsp_acc;
    logic                    st_wr_en;
    logic [AW-1:0]           st_addr;
    logic [WORD_W-1:0]       st_data;
    logic [WORDS*WORD_W-1:0] words_flat;

    // Only the current owner may write; the two sides never collide.
    always_comb begin
        req_acc  = req_wr_en && !rsp_owns;
        rsp_acc  = rsp_wr_en &&  rsp_owns;
        st_wr_en = req_acc || rsp_acc;
        st_addr  = rsp_acc ? rsp_addr  : req_addr;
        st_data  = rsp_acc ? rsp_wdata : req_wdata;
    end

    mbox_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (st_wr_en),
        .wr_addr    (st_addr),
        .wr_data    (st_data),
        .words_flat (words_flat)
    );

    mbox_owner u_owner (
        .clk    (clk),
        .rst    (rst),
        .take   (req_acc && (req_addr == LAST_A)),
        .give   (rsp_acc && (rsp_addr == LAST_A)),
        .owned  (rsp_owns),
        .notify (rsp_notify)
    );

    mbox_readmux #(.WORDS(WORDS), .WORD_W(WORD_W)) u_req_rd (
        .words_flat (words_flat),
        .addr       (req_addr),
        .owned      (rsp_owns),
        .force_ones (req_hold),
        .rdata      (req_rdata)
    );

    mbox_readmux #(.WORDS(WORDS), .WORD_W(WORD_W)) u_rsp_rd (
        .words_flat (words_flat),
        .addr       (rsp_addr),
        .owned      (rsp_owns),
        .force_ones (1'b0),
        .rdata      (rsp_rdata)
    );
endmodule

// File: rtl/mbox_window_chk.sv
module mbox_window_chk #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 32,
    localparam int AW    = $clog2(WORDS),
    localparam logic [AW-1:0] LAST_A = AW'(WORDS - 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_hold,
    input logic              req_wr_en,
    input logic [AW-1:0]     req_addr,
    input logic [WORD_W-1:0] req_rdata,
    input logic              rsp_wr_en,
    input logic [AW-1:0]     rsp_addr,
    input logic [WORD_W-1:0] rsp_rdata,
    input logic              rsp_owns,
    input logic              rsp_notify
);
    AST_RESET_OWNER: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rsp_owns && !rsp_notify); // R1

    AST_HANDOFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_owns) |-> $past(req_wr_en) && ($past(req_addr) == LAST_A)); // R3

    AST_NOTIFY_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        rsp_notify |-> rsp_owns && !$past(rsp_owns)); // R4

    AST_NOTIFY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rsp_notify |=> !rsp_notify); // R4

    AST_RISE_NOTIFIES: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_owns) |-> rsp_notify); // R4

    AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(rsp_owns) |-> $past(rsp_wr_en) && ($past(rsp_addr) == LAST_A)); // R7

    AST_OWNER_BIT_VIEW: assert property (@(posedge clk) disable iff (rst)
        (rsp_addr == LAST_A) |-> rsp_rdata[WORD_W-1] == rsp_owns); // R3

    AST_HOLD_READBACK: assert property (@(posedge clk) disable iff (rst)
        (req_hold && req_addr == LAST_A) |-> (req_rdata == '1)); // R8
endmodule

bind mbox_window mbox_window_chk #(.WORDS(WORDS), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_hold   (req_hold),
    .req_wr_en  (req_wr_en),
    .req_addr   (req_addr),
    .req_rdata  (req_rdata),
    .rsp_wr_en  (rsp_wr_en),
    .rsp_addr   (rsp_addr),
    .rsp_rdata  (rsp_rdata),
    .rsp_owns   (rsp_owns),
    .rsp_notify (rsp_notify)
);

// File: tb/mbox_window_bench.sv
module mbox_window_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        side;   // 0 requester, 1 responder
        logic [2:0]  addr;
        logic [31:0] data;
        logic        owner;  // expected rsp_owns after the write
        logic [31:0] rd;     // expected responder-port read of addr
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 32'h1111_1111, 1'b0, 32'h1111_1111}, // R2
        '{1'b0, 3'd6, 32'h6666_0006, 1'b0, 32'h6666_0006}, // R2
        '{1'b1, 3'd0, 32'hDEAD_0000, 1'b0, 32'h1111_1111}, // R6
        '{1'b0, 3'd7, 32'h0100_0001, 1'b1, 32'h8100_0001}, // R3
        '{1'b0, 3'd1, 32'h0000_0BAD, 1'b1, 32'h0000_0000}, // R5
        '{1'b1, 3'd2, 32'h0000_0022, 1'b1, 32'h0000_0022}, // R7
        '{1'b1, 3'd7, 32'h8000_0081, 1'b0, 32'h0000_0081}, // R7
        '{1'b0, 3'd7, 32'h0000_0002, 1'b1, 32'h8000_0002}, // R9
        '{1'b1, 3'd7, 32'h0000_0182, 1'b0, 32'h0000_0182}  // R7
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_hold, req_wr_en, rsp_wr_en;
    logic [2:0]  req_addr, rsp_addr;
    logic [31:0] req_wdata, rsp_wdata, req_rdata, rsp_rdata;
    logic        rsp_owns, rsp_notify;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_window u_mbox_window (
        .clk(clk), .rst(rst), .req_hold(req_hold),
        .req_wr_en(req_wr_en), .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
        .rsp_wr_en(rsp_wr_en), .rsp_addr(rsp_addr), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
        .rsp_owns(rsp_owns), .rsp_notify(rsp_notify)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // One-cycle write; returns at the falling edge after the capturing edge.
    task automatic wr(input logic side, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        if (side) begin rsp_wr_en = 1'b1; rsp_addr = a; rsp_wdata = d; end
        else      begin req_wr_en = 1'b1; req_addr = a; req_wdata = d; end
        @(negedge clk);
        req_wr_en = 1'b0;
        rsp_wr_en = 1'b0;
    endtask

    task automatic rsp_rd(input logic [2:0] a, output logic [31:0] d);
        rsp_addr = a; #1; d = rsp_rdata;
    endtask

    task automatic req_rd(input logic [2:0] a, output logic [31:0] d);
        req_addr = a; #1; d = req_rdata;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] v;
        logic        own_m;
        rst = 1'b1; req_hold = 1'b0; req_wr_en = 1'b0; rsp_wr_en = 1'b0;
        req_addr = '0; rsp_addr = '0; req_wdata = '0; rsp_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 owner", {31'b0, rsp_owns}, 32'd0);
        chk("R1 notify", {31'b0, rsp_notify}, 32'd0);
        for (int w = 0; w < 8; w++) begin
            rsp_rd(3'(w), v);
            chk("R1 word", v, 32'd0);
        end

        own_m = 1'b0;
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].side, VEC[i].addr, VEC[i].data);
            chk("R4 notify", {31'b0, rsp_notify},
                {31'b0, (VEC[i].side == 1'b0 && VEC[i].addr == 3'd7 && !own_m)});
            chk("R3/R5/R6/R7 owner", {31'b0, rsp_owns}, {31'b0, VEC[i].owner});
            rsp_rd(VEC[i].addr, v);
            chk("R2/R3/R5/R6/R7 read", v, VEC[i].rd);
            @(negedge clk);
            chk("R4 pulse ends", {31'b0, rsp_notify}, 32'd0);
            own_m = VEC[i].owner;
        end

        // R9: word-7-only message left words 0 and 6 untouched
        rsp_rd(3'd0, v); chk("R9 word0", v, 32'h1111_1111);
        rsp_rd(3'd6, v); chk("R9 word6", v, 32'h6666_0006);
        req_rd(3'd6, v); chk("R2 req port", v, 32'h6666_0006);

        // R8: requester reset override
        @(negedge clk); req_hold = 1'b1;
        req_rd(3'd7, v); chk("R8 hold word7", v, 32'hFFFF_FFFF);
        req_rd(3'd0, v); chk("R8 hold word0", v, 32'h1111_1111);
        rsp_rd(3'd7, v); chk("R8 rsp port", v, 32'h0000_0182);
        @(negedge clk); req_hold = 1'b0;
        req_rd(3'd7, v); chk("R8 release", v, 32'h0000_0182);

        // R3: written bit 31 ignored on handoff
        wr(1'b0, 3'd7, 32'h8000_0001);
        req_rd(3'd7, v); chk("R3 owner bit", v, 32'h8000_0001);

        // R1: reset mid-run clears words and ownership
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 rerun owner", {31'b0, rsp_owns}, 32'd0);
        rsp_rd(3'd0, v); chk("R1 rerun word0", v, 32'd0);
        rsp_rd(3'd7, v); chk("R1 rerun word7", v, 32'd0);

        summary();
    end
endmodule